// File: doc/BRIEF.md
# RTC Interrupt Generator with Alarm Masking

This block merges three interrupt sources of a real-time clock into one active-low request line: a periodic tick derived from a 32.768 kHz timebase, a time-of-day alarm, and a power-fail event. Each source has a sticky flag and an enable bit. A flag is set whenever its event occurs. The request line is driven only for flags whose enable bit is set. The calendar counters and the host bus decoding sit outside the block. The block receives the current time bytes, a once-per-second update strobe and single-cycle register-access strobes.

The host clears all three flags with one read of the flag register. That read takes effect only if the address has rested on the flag register long enough beforehand, so a glitching address cannot wipe pending events. Two mask bits in each alarm byte let the alarm repeat every second, minute, hour or day. A separate enable lets the alarm alone keep the request line active while the system runs from its backup battery.

Top module: `rtc_irq_top`

## Requirements
- R1: After reset the alarm flag, periodic flag and power-fail flag are 0, the enable, rate and alarm registers are 0, and `irq_no` is 1.
- R2: The rate register (address 0xB, bits 3:0) selects the periodic period. Code 0 never sets the periodic flag. Code n from 1 to 15 sets it on the 2^(n-1)-th `tick_i` edge after the edge at which the rate register was written. Any write to the rate register restarts the count.
- R3: A flag is set by its event whatever its enable bit is. When `bkup_i` is 0, `irq_no` is 0 exactly while some flag and its enable are both 1. The enable register is at address 0xC: bit 3 alarm, bit 2 periodic, bit 1 power-fail, bit 0 alarm-in-backup.
- R4: A read strobe at address 0xD clears the alarm, periodic and power-fail flags at that edge only if the address has equalled 0xD for at least HOLD_CYC consecutive edges before that edge. A shorter hold leaves the flags unchanged.
- R5: A read at address 0xD returns bit 3 alarm flag, bit 2 periodic flag, bit 1 power-fail flag, bit 0 the level of `batt_ok_i`, and bits 7:4 as 0.
- R6: At an edge with `upd_i` high, the alarm flag is set if every alarm byte (seconds 0x1, minutes 0x3, hours 0x5, date 0x7) equals its time input in all 8 bits. A byte whose bits 7:6 are both 1 is ignored in the comparison. Without `upd_i` the alarm flag is never set.
- R7: Masking all four bytes gives an alarm at every update. Masking minutes, hours and date gives one per minute. Masking hours and date gives one per hour. Masking date only gives one per day. A byte with only one of its two mask bits set is still compared.
- R8: While `bkup_i` is 1, `irq_no` is 0 only when the alarm flag, the alarm enable and the alarm-in-backup enable are all 1.
- R9: A `pwr_fail_i` pulse sets the power-fail flag at that edge.
- R10: An event at the same edge as a qualifying clearing read leaves its flag set.
- R11: Writes to the flag register address 0xD have no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| upd_i | input | 1 | Once-per-second update strobe |
| sec_i | input | 8 | Current seconds, BCD |
| min_i | input | 8 | Current minutes, BCD |
| hour_i | input | 8 | Current hours, BCD |
| date_i | input | 8 | Current day of month, BCD |
| pwr_fail_i | input | 1 | Power-fail event pulse |
| bkup_i | input | 1 | System is on battery backup |
| batt_ok_i | input | 1 | Backup battery valid level |
| reg_addr_i | input | 4 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the current address, combinational |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
All flags are registered and `irq_no` and `reg_rdata_o` are combinational from them. An event, a write or a clearing read sampled at one edge therefore shows up at the ports right after that edge. The bench drives on falling edges and samples at the following falling edge, or a nanosecond after a falling edge for address peeks. For the periodic tick it counts falling edges from the write of the rate code until the request line falls, and compares the count with 2^(n-1). The clearing hold is tested at exactly HOLD_CYC and at HOLD_CYC-1 edges.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
   localparam int unsigned ADDR_W     = 4;
   localparam int unsigned DATA_W     = 8;
   localparam int unsigned N_ALM      = 4;
   localparam logic [ADDR_W-1:0] ALM_BASE  = 4'h1;
   localparam logic [ADDR_W-1:0] RATE_ADDR = 4'hB;
   localparam logic [ADDR_W-1:0] EN_ADDR   = 4'hC;
   localparam logic [ADDR_W-1:0] FLAG_ADDR = 4'hD;
   // enable bit positions
   localparam int unsigned EN_ALM  = 3;
   localparam int unsigned EN_PER  = 2;
   localparam int unsigned EN_PWR  = 1;
   localparam int unsigned EN_BKA  = 0;
   // internal flag vector positions
   localparam int unsigned FL_ALM  = 2;
   localparam int unsigned FL_PER  = 1;
   localparam int unsigned FL_PWR  = 0;
   localparam int unsigned N_FLAGS = 3;
endpackage

// File: rtl/rtc_irq_rate.sv
module rtc_irq_rate #(
   parameter int unsigned RATE_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              restart_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic              evt_o
);
   localparam int unsigned NCODE = 1 << RATE_W;
   localparam int unsigned DIV_W = (NCODE > 3) ? NCODE - 2 : 1;

   if (RATE_W < 2) begin : g_bad
      $error("rtc_irq_rate: RATE_W must be at least 2");
   end

   logic [DIV_W-1:0] cnt_q;
   logic [NCODE-1:0] term;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cnt_q <= '0;
      else if (restart_i) cnt_q <= '0;
      else if (tick_i)    cnt_q <= cnt_q + 1'b1;
   end

   assign term[0] = 1'b0;
   assign term[1] = 1'b1;
   for (genvar c = 2; c < NCODE; c++) begin : g_term
      assign term[c] = &cnt_q[c-2:0];
   end

   assign evt_o = tick_i & ~restart_i & term[rate_i];
endmodule

// File: rtl/rtc_irq_alarm.sv
module rtc_irq_alarm #(
   parameter int unsigned N_BYTES = 4,
   parameter int unsigned BYTE_W  = 8
) (
   input  logic [N_BYTES*BYTE_W-1:0] cur_i,
   input  logic [N_BYTES*BYTE_W-1:0] alm_i,
   input  logic                      upd_i,
   output logic                      hit_o
);
   if (BYTE_W < 3) begin : g_bad
      $error("rtc_irq_alarm: BYTE_W too small for mask bits");
   end

   logic [N_BYTES-1:0] ok;

   for (genvar i = 0; i < N_BYTES; i++) begin : g_cmp
      logic [BYTE_W-1:0] a, t;
      assign a     = alm_i[i*BYTE_W +: BYTE_W];
      assign t     = cur_i[i*BYTE_W +: BYTE_W];
      assign ok[i] = (&a[BYTE_W-1 -: 2]) | (a == t);
   end

   assign hit_o = upd_i & (&ok);
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
   parameter int unsigned N_FLAGS  = 3,
   parameter int unsigned HOLD_CYC = 10
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               addr_hit_i,
   input  logic               rd_i,
   input  logic [N_FLAGS-1:0] set_i,
   output logic [N_FLAGS-1:0] flags_o
);
   localparam int unsigned HW = $clog2(HOLD_CYC + 1);
   localparam logic [HW-1:0] HOLD_V = HW'(HOLD_CYC);

   if (HOLD_CYC < 1) begin : g_bad
      $error("rtc_irq_flags: HOLD_CYC must be at least 1");
   end

   logic [HW-1:0] hold_q;
   logic          clr;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              hold_q <= '0;
      else if (!addr_hit_i)     hold_q <= '0;
      else if (hold_q != HOLD_V) hold_q <= hold_q + 1'b1;
   end

   assign clr = rd_i & addr_hit_i & (hold_q == HOLD_V);

   for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)       q <= 1'b0;
         else if (set_i[f]) q <= 1'b1;
         else if (clr)      q <= 1'b0;
      end
      assign flags_o[f] = q;
   end
endmodule

// File: rtl/rtc_irq_top.sv
module rtc_irq_top
   import rtc_irq_pkg::*;
#(
   parameter int unsigned RATE_W   = 4,
   parameter int unsigned HOLD_CYC = 10
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        tick_i,
   input  logic        upd_i,
   input  logic [7:0]  sec_i,
   input  logic [7:0]  min_i,
   input  logic [7:0]  hour_i,
   input  logic [7:0]  date_i,
   input  logic        pwr_fail_i,
   input  logic        bkup_i,
   input  logic        batt_ok_i,
   input  logic [3:0]  reg_addr_i,
   input  logic        reg_wr_i,
   input  logic        reg_rd_i,
   input  logic [7:0]  reg_wdata_i,
   output logic [7:0]  reg_rdata_o,
   output logic        irq_no
);
   if (RATE_W > 4) begin : g_bad
      $error("rtc_irq_top: rate field must fit in 4 bits");
   end

   logic [N_ALM*DATA_W-1:0] alm_q;
   logic [N_ALM*DATA_W-1:0] cur;
   logic [RATE_W-1:0]       rate_q;
   logic [3:0]              en_q;
   logic [N_FLAGS-1:0]      flags_w;
   logic [N_FLAGS-1:0]      set_w;
   logic                    rate_wr, per_evt, alm_hit;
   logic                    irq_norm, irq_bk;

   assign rate_wr = reg_wr_i & (reg_addr_i == RATE_ADDR);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rate_q <= '0;
         en_q   <= '0;
      end else begin
         if (rate_wr) rate_q <= reg_wdata_i[RATE_W-1:0];
         if (reg_wr_i && reg_addr_i == EN_ADDR) en_q <= reg_wdata_i[3:0];
      end
   end

   for (genvar i = 0; i < N_ALM; i++) begin : g_alm
      localparam logic [ADDR_W-1:0] MY_ADDR = ALM_BASE + ADDR_W'(2*i);
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            alm_q[i*DATA_W +: DATA_W] <= '0;
         else if (reg_wr_i && reg_addr_i == MY_ADDR)
            alm_q[i*DATA_W +: DATA_W] <= reg_wdata_i;
      end
   end

   assign cur = {date_i, hour_i, min_i, sec_i};

   rtc_irq_rate #(.RATE_W(RATE_W)) u_rate (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .restart_i (rate_wr),
      .rate_i    (rate_q),
      .evt_o     (per_evt)
   );

   rtc_irq_alarm #(.N_BYTES(N_ALM), .BYTE_W(DATA_W)) u_alarm (
      .cur_i (cur),
      .alm_i (alm_q),
      .upd_i (upd_i),
      .hit_o (alm_hit)
   );

   always_comb begin
      set_w         = '0;
      set_w[FL_ALM] = alm_hit;
      set_w[FL_PER] = per_evt;
      set_w[FL_PWR] = pwr_fail_i;
   end

   rtc_irq_flags #(.N_FLAGS(N_FLAGS), .HOLD_CYC(HOLD_CYC)) u_flags (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .addr_hit_i (reg_addr_i == FLAG_ADDR),
      .rd_i       (reg_rd_i),
      .set_i      (set_w),
      .flags_o    (flags_w)
   );

   assign irq_norm = (flags_w[FL_ALM] & en_q[EN_ALM])
                   | (flags_w[FL_PER] & en_q[EN_PER])
                   | (flags_w[FL_PWR] & en_q[EN_PWR]);
   assign irq_bk   = flags_w[FL_ALM] & en_q[EN_ALM] & en_q[EN_BKA];
   assign irq_no   = ~(bkup_i ? irq_bk : irq_norm);

   always_comb begin
      reg_rdata_o = '0;
      for (int i = 0; i < N_ALM; i++) begin
         if (reg_addr_i == ALM_BASE + ADDR_W'(2*i))
            reg_rdata_o = alm_q[i*DATA_W +: DATA_W];
      end
      case (reg_addr_i)
         RATE_ADDR: reg_rdata_o = {{(DATA_W-RATE_W){1'b0}}, rate_q};
         EN_ADDR:   reg_rdata_o = {4'b0, en_q};
         FLAG_ADDR: reg_rdata_o = {4'b0, flags_w[FL_ALM], flags_w[FL_PER],
                                   flags_w[FL_PWR], batt_ok_i};
         default: ;
      endcase
   end
endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk #(
   parameter int unsigned HOLD_CYC = 10,
   parameter int unsigned RATE_W   = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              reg_rd_i,
   input logic [3:0]        reg_addr_i,
   input logic              pwr_fail_i,
   input logic              upd_i,
   input logic              bkup_i,
   input logic              irq_no,
   input logic [2:0]        flags_w,
   input logic [RATE_W-1:0] rate_q
);
   int unsigned seen;
   logic        at_flag, rd_flag;

   assign at_flag = (reg_addr_i == 4'hD);
   assign rd_flag = reg_rd_i & at_flag;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       seen <= 0;
      else if (!at_flag) seen <= 0;
      else if (seen < HOLD_CYC) seen <= seen + 1;
   end

   // R9
   pwr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwr_fail_i |=> flags_w[0]);
   // R4
   hold_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_flag && seen >= HOLD_CYC && !pwr_fail_i) |=> !flags_w[0]);
   // R4
   short_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_flag && seen < HOLD_CYC && flags_w[0]) |=> flags_w[0]);
   // R6
   alarm_only_on_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!upd_i && !flags_w[2]) |=> !flags_w[2]);
   // R2
   rate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rate_q == '0 && !flags_w[1]) |=> !flags_w[1]);
   // R8
   backup_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bkup_i && !flags_w[2]) |-> irq_no);
endmodule

bind rtc_irq_top rtc_irq_chk #(.HOLD_CYC(HOLD_CYC), .RATE_W(RATE_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .reg_rd_i   (reg_rd_i),
   .reg_addr_i (reg_addr_i),
   .pwr_fail_i (pwr_fail_i),
   .upd_i      (upd_i),
   .bkup_i     (bkup_i),
   .irq_no     (irq_no),
   .flags_w    (flags_w),
   .rate_q     (rate_q)
);

// File: tb/rtc_irq_top_tb.sv
`timescale 1ns/1ps
module rtc_irq_top_tb;
   localparam int HOLD = 10;

   logic clk = 0, rst_n = 0;
   logic tick = 1, upd = 0, pwr = 0, bkup = 0, batt = 1;
   logic [7:0] sec = 0, mn = 0, hr = 0, dt = 0;
   logic [3:0] addr = 0;
   logic wr = 0, rd = 0;
   logic [7:0] wdata = 0;
   logic [7:0] rdata;
   logic irq_n;
   int checks = 0, errs = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   rtc_irq_top #(.RATE_W(4), .HOLD_CYC(HOLD)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .upd_i(upd),
      .sec_i(sec), .min_i(mn), .hour_i(hr), .date_i(dt),
      .pwr_fail_i(pwr), .bkup_i(bkup), .batt_ok_i(batt),
      .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_no(irq_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1;
      @(negedge clk); wr = 0; addr = 0;
   endtask

   task automatic peek(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; #1 d = rdata;
   endtask

   // read the flag register after holding the address for n edges
   task automatic flag_read(input int n, input bit pulse_pwr);
      @(negedge clk); addr = 0;
      @(negedge clk); addr = 4'hD;
      repeat (n) @(negedge clk);
      rd = 1; pwr = pulse_pwr;
      @(negedge clk); rd = 0; pwr = 0; addr = 0;
   endtask

   task automatic strobe_upd;
      @(negedge clk); upd = 1;
      @(negedge clk); upd = 0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog: got hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errs);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [7:0] v [4];
      v[0] = 8'h25; v[1] = 8'h14; v[2] = 8'h09; v[3] = 8'h17;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 / R5 reset state and read layout
      peek(4'hD, d); chk("R1 flags", d, 8'h01);
      peek(4'hC, d); chk("R1 enables", d, 0);
      peek(4'hB, d); chk("R1 rate", d, 0);
      peek(4'h5, d); chk("R1 alarm byte", d, 0);
      chk("R1 irq", irq_n, 1);
      batt = 0; peek(4'hD, d); chk("R5 battery bit", d, 8'h00); batt = 1;

      // R9 / R3 power-fail sets flag without enable
      @(negedge clk); pwr = 1; @(negedge clk); pwr = 0;
      peek(4'hD, d); chk("R9 pwr flag", d, 8'h03);
      chk("R3 disabled no irq", irq_n, 1);
      wr_reg(4'hC, 8'h02); #1 chk("R3 enabled irq", irq_n, 0);
      // R11 write to flag register ignored
      wr_reg(4'hD, 8'h00); peek(4'hD, d); chk("R11 write ignored", d, 8'h03);
      // R4 short hold keeps, full hold clears
      flag_read(HOLD - 1, 0); peek(4'hD, d); chk("R4 short hold", d, 8'h03);
      flag_read(HOLD, 0); peek(4'hD, d); chk("R4 clear", d, 8'h01);
      chk("R4 irq released", irq_n, 1);
      // R10 event coinciding with clear survives
      flag_read(HOLD, 1); peek(4'hD, d); chk("R10 set wins", d, 8'h03);
      flag_read(HOLD, 0);

      // R2 periodic rate sweep
      for (int n = 1; n < 16; n++) begin
         int k;
         wr_reg(4'hB, 0); flag_read(HOLD, 0);
         wr_reg(4'hC, 8'h04);
         wr_reg(4'hB, 8'(n));
         k = 0;
         while (irq_n && k < 20000) begin @(negedge clk); k++; end
         chk($sformatf("R2 code %0d period", n), k, 1 << (n - 1));
      end
      wr_reg(4'hB, 0); flag_read(HOLD, 0);
      repeat (300) @(negedge clk);
      peek(4'hD, d); chk("R2 code 0 off", d[2], 0);
      wr_reg(4'hC, 0);

      // R6 / R7 alarm mask sweep: masks x mismatch position
      for (int m = 0; m < 16; m++) begin
         for (int bad = -1; bad < 4; bad++) begin
            bit exp;
            for (int i = 0; i < 4; i++)
               wr_reg(4'(1 + 2 * i), m[i] ? (v[i] | 8'hC0) : v[i]);
            sec = v[0]; mn = v[1]; hr = v[2]; dt = v[3];
            case (bad)
               0: sec = v[0] ^ 8'h01;
               1: mn  = v[1] ^ 8'h01;
               2: hr  = v[2] ^ 8'h01;
               3: dt  = v[3] ^ 8'h01;
               default: ;
            endcase
            flag_read(HOLD, 0);
            strobe_upd;
            peek(4'hD, d);
            exp = (bad < 0) ? 1'b1 : m[bad];
            // R7 masks 1111 every second, 1110 per minute, 1100 per hour, 1000 per day
            chk($sformatf("R6 R7 mask %b miss %0d", 4'(m), bad), d[3], exp);
         end
      end
      // R7 a single mask bit does not mask the byte
      wr_reg(4'h1, v[0] | 8'h40); sec = v[0]; mn = v[1]; hr = v[2]; dt = v[3];
      wr_reg(4'h3, v[1]); wr_reg(4'h5, v[2]); wr_reg(4'h7, v[3]);
      flag_read(HOLD, 0); strobe_upd; peek(4'hD, d);
      chk("R7 half mask compared", d[3], 0);
      // R6 match without update strobe does not set
      wr_reg(4'h1, v[0]); flag_read(HOLD, 0);
      repeat (5) @(negedge clk); peek(4'hD, d);
      chk("R6 no strobe no flag", d[3], 0);

      // R8 backup behaviour
      bkup = 1; wr_reg(4'hC, 8'h0E);
      @(negedge clk); pwr = 1; @(negedge clk); pwr = 0; #1
      chk("R8 pwr masked in backup", irq_n, 1);
      strobe_upd; #1 chk("R8 alarm without backup enable", irq_n, 1);
      wr_reg(4'hC, 8'h0F); #1 chk("R8 alarm in backup", irq_n, 0);
      wr_reg(4'hC, 8'h01); #1 chk("R8 backup enable alone", irq_n, 1);
      bkup = 0; wr_reg(4'hC, 8'h02); #1 chk("R3 back to normal", irq_n, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   end
endmodule